// File: doc/BRIEF.md
# Consumer-IR Auxiliary Status Controller

This block holds the auxiliary status and control register of an infrared-capable serial port, together with the small transmit and receive control state behind its bits. The CPU reads and writes the register at a single offset while the port is in extended mode. The block also watches events from the transmit FIFO, the receive FIFO, the receive timeout timer, the pulse detector and the mode field. From these it drives a transmitter-enable, a receiver-enable and the register's read value.

On the transmit side, software arms an end-of-message marker before it loads the final character. The block then tells a clean stop at the end of a message apart from an underrun, which freezes the transmitter until software acknowledges it. On the receive side, the block keeps a timeout flag, an activity flag that turns the receiver on and off, and a watchdog flag that software polls to find idle periods. Each flag has its own clear rule: clear-on-read, write-1-to-clear, cleared by a FIFO access, or cleared by leaving consumer-IR mode. Separate transmit and receive soft resets clear their own halves.

Top module: `cir_aux_status`

## Requirements
- R1: After hardware reset every flag is 0, `tx_en` is 1 and `rx_en` is 0.
- R2: While `ext_mode` is 1, `rdata` shows receive timeout at bit 0, end-of-message at bit 2, watchdog at bit 4, receiver active at bit 5 and underrun at bit 6. Bits 1, 3 and 7 always read 0. While `ext_mode` is 0, `rdata` is 0, and reads and writes have no effect.
- R3: The receive timeout flag is set by `rx_tout` and cleared by `rxf_rd`. If both arrive in the same cycle, the set wins. Register writes do not change it.
- R4: In consumer-IR mode, the watchdog flag is set by `pulse_det` and cleared by a register read (`reg_sel` and `reg_rd` with `ext_mode`). A pulse in the same cycle as the read wins. Writes do not change it.
- R5: In consumer-IR mode, the receiver-active flag is set by `pulse_det` and cleared by writing 1 to bit 5. `rx_en` equals this flag.
- R6: In consumer-IR mode, writing 1 to bit 2 sets the end-of-message flag. The next `txf_wr` clears it and marks the character just written as the last one.
- R7: A `tx_drain` while the transmitter is enabled and the newest character is marked last is a clean stop. `tx_en` goes to 0, no underrun is raised, and `tx_en` returns to 1 after the next `txf_wr`.
- R8: A `tx_drain` while the transmitter is enabled and the newest character is not marked last sets the underrun flag, and `tx_en` goes to 0. Further `txf_wr` events do not clear the flag, and a `tx_drain` while `tx_en` is 0 has no effect.
- R9: Writing 1 to bit 6 clears the underrun flag. If a `txf_wr` arrives in the same cycle, both take effect and `tx_en` is 1 from the next cycle.
- R10: While `mode_sel` differs from consumer-IR (code 2), the end-of-message, watchdog, receiver-active and underrun flags and the stop state are held at 0. Writes and pulses that would change them are ignored. The flags stay 0 after returning to consumer-IR.
- R11: `tx_srst` clears end-of-message, underrun and the stop state. `rx_srst` clears receive timeout, watchdog and receiver active, and takes priority over a same-cycle set.
- R12: Each flag changes at the first rising clock edge after its event. `rdata`, `tx_en` and `rx_en` follow the flags with no further register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| ext_mode | input | 1 | Extended register set selected |
| mode_sel | input | MODE_W | Port operating mode; CIR_MODE (2) is consumer-IR |
| reg_sel | input | 1 | CPU access addresses this register |
| reg_wr | input | 1 | CPU write strobe |
| reg_rd | input | 1 | CPU read strobe |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | Register read value |
| txf_wr | input | 1 | A character was written into the TX FIFO |
| tx_drain | input | 1 | Transmitter finished a character and found the TX FIFO empty |
| rxf_rd | input | 1 | A character was read from the RX FIFO |
| rx_tout | input | 1 | RX FIFO timeout event |
| pulse_det | input | 1 | IR pulse or pulse train detected |
| tx_srst | input | 1 | Transmitter soft reset |
| rx_srst | input | 1 | Receiver soft reset |
| tx_en | output | 1 | Transmitter allowed to send |
| rx_en | output | 1 | Receiver active and sampling |

## Verification
Every flag is one register stage from its event, so its effect is due at the first rising edge after the stimulus. `rdata`, `tx_en` and `rx_en` are combinational views of those flags and are valid right after that edge. The bench applies each stimulus at a falling edge and checks at the next falling edge, half a period after the update, before the next stimulus is applied. Observing `rdata` needs no read strobe, so the clear-on-read watchdog is disturbed only by the vectors that read on purpose.

// File: rtl/cir_aux_status.sv
`timescale 1ns/1ps
module cir_aux_status #(
  parameter int MODE_W = 3,
  parameter logic [MODE_W-1:0] CIR_MODE = MODE_W'(2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_mode,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              txf_wr,
  input  logic              tx_drain,
  input  logic              rxf_rd,
  input  logic              rx_tout,
  input  logic              pulse_det,
  input  logic              tx_srst,
  input  logic              rx_srst,
  output logic              tx_en,
  output logic              rx_en
);
  localparam int B_TOUT = 0;
  localparam int B_EOM  = 2;
  localparam int B_WDG  = 4;
  localparam int B_ACT  = 5;
  localparam int B_UR   = 6;

  logic is_cir, acc_wr, acc_rd, tx_go;
  logic tout_q, eom_q, wdg_q, act_q, ur_q, last_q, stop_q;

  assign is_cir = (mode_sel == CIR_MODE);
  assign acc_wr = reg_sel & reg_wr & ext_mode;
  assign acc_rd = reg_sel & reg_rd & ext_mode;
  assign tx_en  = ~ur_q & ~stop_q;
  assign rx_en  = act_q;
  assign tx_go  = tx_drain & tx_en & is_cir;

  always_comb begin
    rdata = '0;
    if (ext_mode) begin
      rdata[B_TOUT] = tout_q;
      rdata[B_EOM]  = eom_q;
      rdata[B_WDG]  = wdg_q;
      rdata[B_ACT]  = act_q;
      rdata[B_UR]   = ur_q;
    end
  end

  // receive side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tout_q <= 1'b0;
      wdg_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      if (rx_srst)      tout_q <= 1'b0;
      else if (rx_tout) tout_q <= 1'b1;
      else if (rxf_rd)  tout_q <= 1'b0;

      if (rx_srst || !is_cir) wdg_q <= 1'b0;
      else if (pulse_det)     wdg_q <= 1'b1;
      else if (acc_rd)        wdg_q <= 1'b0;

      if (rx_srst || !is_cir)         act_q <= 1'b0;
      else if (acc_wr && wdata[B_ACT]) act_q <= 1'b0;
      else if (pulse_det)              act_q <= 1'b1;
    end
  end

  // transmit side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eom_q  <= 1'b0;
      last_q <= 1'b0;
      stop_q <= 1'b0;
      ur_q   <= 1'b0;
    end else if (tx_srst || !is_cir) begin
      eom_q  <= 1'b0;
      last_q <= 1'b0;
      stop_q <= 1'b0;
      ur_q   <= 1'b0;
    end else begin
      if (acc_wr && wdata[B_EOM]) eom_q <= 1'b1;
      else if (txf_wr)            eom_q <= 1'b0;

      if (txf_wr)     last_q <= eom_q;
      else if (tx_go) last_q <= 1'b0;

      if (txf_wr)               stop_q <= 1'b0;
      else if (tx_go && last_q) stop_q <= 1'b1;

      if (acc_wr && wdata[B_UR]) ur_q <= 1'b0;
      else if (tx_go && !last_q) ur_q <= 1'b1;
    end
  end

  // R8
  ur_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ur_q) |-> $past(tx_drain && tx_en && !last_q));

  // R7
  clean_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> ($past(last_q && tx_drain) && !ur_q));

  // R4
  wdg_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_det && is_cir && !rx_srst) |=> wdg_q);

  // R10
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cir |=> !(ur_q || eom_q || act_q || wdg_q || stop_q));

  // R11
  rx_srst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_srst |=> !(tout_q || wdg_q || act_q));

  // R9
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && wdata[B_UR] && txf_wr && is_cir && !tx_srst) |=> tx_en);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[1] == 1'b0) && (rdata[3] == 1'b0) && (rdata[7] == 1'b0));
endmodule

// File: tb/cir_aux_status_bench.sv
`timescale 1ns/1ps
module cir_aux_status_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_mode, reg_sel, reg_wr, reg_rd, txf_wr, tx_drain, rxf_rd, rx_tout, pulse_det, tx_srst, rx_srst;
  logic [2:0] mode_sel;
  logic [7:0] wdata, rdata;
  logic tx_en, rx_en;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  cir_aux_status u_cir_aux_status (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .mode_sel(mode_sel),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .wdata(wdata), .rdata(rdata),
    .txf_wr(txf_wr), .tx_drain(tx_drain), .rxf_rd(rxf_rd), .rx_tout(rx_tout),
    .pulse_det(pulse_det), .tx_srst(tx_srst), .rx_srst(rx_srst), .tx_en(tx_en), .rx_en(rx_en)
  );

  typedef struct packed {
    logic [2:0] mode; logic ext, wr, rd; logic [7:0] wd;
    logic txw, drn, rxr, tout, pls, tsr, rsr;
    logic [7:0] ef; logic etx, erx; logic [3:0] req;
  } vec_t;

  localparam logic [2:0] C = 3'd2;
  localparam logic [2:0] O = 3'd0;
  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{C,1,0,0,8'h00,0,0,0,0,0,0,0,8'h00,1,0,4'd1},  // R1 idle
    '{C,1,0,0,8'h00,0,0,0,0,1,0,0,8'h30,1,1,4'd5},  // R5 pulse
    '{C,1,0,1,8'h00,0,0,0,0,0,0,0,8'h20,1,1,4'd4},  // R4 read clears
    '{C,1,0,1,8'h00,0,0,0,0,1,0,0,8'h30,1,1,4'd4},  // R4 set wins
    '{C,1,1,0,8'h20,0,0,0,0,0,0,0,8'h10,1,0,4'd5},  // R5 w1c
    '{C,1,0,0,8'h00,0,0,0,1,0,0,0,8'h11,1,0,4'd3},  // R3
    '{C,1,0,0,8'h00,0,0,1,0,0,0,0,8'h10,1,0,4'd3},  // R3
    '{C,1,0,0,8'h00,0,0,0,0,0,0,1,8'h00,1,0,4'd11}, // R11
    '{C,1,0,0,8'h00,0,1,0,0,0,0,0,8'h40,0,0,4'd8},  // R8 underrun
    '{C,1,0,0,8'h00,1,0,0,0,0,0,0,8'h40,0,0,4'd8},  // R8 sticky
    '{C,1,1,0,8'h40,0,0,0,0,0,0,0,8'h00,1,0,4'd9},  // R9
    '{C,1,1,0,8'h04,0,0,0,0,0,0,0,8'h04,1,0,4'd6},  // R6
    '{C,1,0,0,8'h00,1,0,0,0,0,0,0,8'h00,1,0,4'd6},  // R6
    '{C,1,0,0,8'h00,0,1,0,0,0,0,0,8'h00,0,0,4'd7},  // R7 clean stop
    '{C,1,0,0,8'h00,0,1,0,0,0,0,0,8'h00,0,0,4'd7},  // R7 drain while stopped
    '{C,1,0,0,8'h00,1,0,0,0,0,0,0,8'h00,1,0,4'd7},  // R7 resume
    '{C,1,0,0,8'h00,0,1,0,0,0,0,0,8'h40,0,0,4'd8},  // R8
    '{C,1,1,0,8'h40,1,0,0,0,0,0,0,8'h00,1,0,4'd9},  // R9 both
    '{C,1,1,0,8'h04,0,0,0,0,0,0,0,8'h04,1,0,4'd6},  // R6
    '{C,1,0,0,8'h00,0,0,0,0,0,1,0,8'h00,1,0,4'd11}, // R11
    '{C,1,0,0,8'h00,0,1,0,0,0,0,0,8'h40,0,0,4'd8},  // R8
    '{C,1,0,0,8'h00,0,0,0,0,0,1,0,8'h00,1,0,4'd11}, // R11
    '{C,1,0,0,8'h00,0,1,0,0,0,0,0,8'h40,0,0,4'd8},  // R8
    '{O,1,0,0,8'h00,0,0,0,0,0,0,0,8'h00,1,0,4'd10}, // R10
    '{C,1,0,0,8'h00,0,0,0,0,0,0,0,8'h00,1,0,4'd10}, // R10
    '{O,1,1,0,8'h04,0,0,0,0,1,0,0,8'h00,1,0,4'd10}, // R10
    '{C,1,0,0,8'h00,0,0,0,0,0,0,0,8'h00,1,0,4'd10}, // R10
    '{C,0,0,0,8'h00,0,0,0,0,1,0,0,8'h00,1,1,4'd2},  // R2 non-ext
    '{C,1,0,0,8'h00,0,0,0,0,0,0,0,8'h30,1,1,4'd2},  // R2
    '{C,1,1,0,8'hff,0,0,0,0,0,0,0,8'h14,1,0,4'd2},  // R2 reserved
    '{C,1,0,0,8'h00,0,0,0,0,0,0,1,8'h04,1,0,4'd11}, // R11
    '{C,1,0,0,8'h00,0,0,0,1,0,0,0,8'h05,1,0,4'd3},  // R3
    '{C,1,0,0,8'h00,0,0,0,0,1,0,1,8'h04,1,0,4'd11}, // R11 priority
    '{C,1,0,0,8'h00,0,0,0,0,0,1,0,8'h00,1,0,4'd11}, // R11
    '{C,1,0,0,8'h00,0,0,0,1,0,0,0,8'h01,1,0,4'd3},  // R3
    '{C,1,1,0,8'h01,0,0,0,0,0,0,0,8'h01,1,0,4'd3},  // R3 not writable
    '{C,1,0,0,8'h00,0,0,1,1,0,0,0,8'h01,1,0,4'd3},  // R3 set wins
    '{C,1,0,0,8'h00,0,0,1,0,0,0,0,8'h00,1,0,4'd3},  // R3
    '{C,1,0,0,8'h00,0,0,0,0,1,0,0,8'h30,1,1,4'd4},  // R4
    '{C,0,0,1,8'h00,0,0,0,0,0,0,0,8'h00,1,1,4'd2},  // R2 read ignored
    '{C,1,0,0,8'h00,0,0,0,0,0,0,0,8'h30,1,1,4'd4}   // R4 kept
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    mode_sel = v.mode; ext_mode = v.ext; reg_sel = v.wr | v.rd; reg_wr = v.wr; reg_rd = v.rd;
    wdata = v.wd; txf_wr = v.txw; tx_drain = v.drn; rxf_rd = v.rxr; rx_tout = v.tout;
    pulse_det = v.pls; tx_srst = v.tsr; rx_srst = v.rsr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    string tag;
    apply('{C,1,0,0,8'h00,0,0,0,0,0,0,0,8'h00,1,0,4'd1});
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", rdata, 8'h00);
    check("R1 tx_en", {7'd0, tx_en}, 8'h01);
    check("R1 rx_en", {7'd0, rx_en}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      check({tag, " rdata"}, rdata, VEC[i].ef);
      check({tag, " tx_en"}, {7'd0, tx_en}, {7'd0, VEC[i].etx});
      check({tag, " rx_en"}, {7'd0, rx_en}, {7'd0, VEC[i].erx});
    end
    // R1 hardware reset mid-run, with an underrun raised as well
    apply('{C,1,0,0,8'h00,0,1,0,0,0,0,0,8'h00,0,0,4'd1});
    @(negedge clk);
    check("R8 pre-reset", rdata, 8'h70);
    apply('{C,1,0,0,8'h00,0,0,0,0,0,0,0,8'h00,0,0,4'd1});
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run rdata", rdata, 8'h00);
    check("R1 mid-run tx_en", {7'd0, tx_en}, 8'h01);
    check("R1 mid-run rx_en", {7'd0, rx_en}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 one edge of latency: flag is not visible before the edge
    pulse_det = 1'b1;
    #1;
    check("R12 before edge", rdata, 8'h00);
    @(negedge clk);
    pulse_det = 1'b0;
    check("R12 after edge", rdata, 8'h30);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule